// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer with Backoff

This block sits between a processor core and an external system bus and runs one bus cycle at a time. A cycle is either a single transfer or a burst of `BURST_LEN` transfers, four by default. The core offers a request made of an address, a direction and a single/burst flag. In the idle state the sequencer accepts it and drives a one-clock address strobe together with the address, direction and write data. It then waits for transfer-ready acknowledgements and counts the beats. On a read it captures the data bus on every acknowledged beat. Two active-low ready inputs are ORed, so either one can acknowledge a transfer.

Another master can claim the bus by pulling the active-low backoff input. The sequencer drops all its output enables on the edge where it samples backoff and stays in a hold state. It discards any beats already acknowledged. When backoff goes away it re-issues the same cycle from its first beat with a fresh address strobe. Backoff always beats a ready seen in the same clock. The core is told that a cycle has finished by a one-clock completion pulse that carries the beat count.

Top module: `bseq_top`

## Requirements
- R1: During and right after a synchronous reset: `bus_ads_n` is 1, `bus_oe`, `bus_data_oe`, `rd_valid` and `done_valid` are 0, and `req_ready` is 1 while `bus_boff_n` is 1.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From that edge, `bus_ads_n` is 0 for exactly one clock, `bus_oe` is 1, and `bus_addr`/`bus_wr` show the request. The address stays unchanged while `bus_oe` stays 1.
- R3: Ready is ignored while idle and in the address-strobe clock. No beat is counted or captured there.
- R4: `bus_rdy_a_n` and `bus_rdy_b_n` are equivalent. Either one at 0 acknowledges a beat.
- R5: On each acknowledged beat of a read, `rd_valid` pulses for one clock, `rd_data` holds the `bus_rdata` sampled at that edge, and `rd_beat` gives the beat index, counting from 0.
- R6: A single cycle ends after one acknowledged beat and a burst after `BURST_LEN`. On the final beat, `done_valid` pulses with `done_beats` equal to 1 or `BURST_LEN`, and `bus_oe` drops.
- R7: On the edge where `bus_boff_n` is sampled 0, `bus_oe` and `bus_data_oe` go to 0. They stay 0 while backoff holds.
- R8: A ready sampled on the same edge as backoff is not counted. It produces no `rd_valid` and no `done_valid`.
- R9: When backoff is released, the interrupted cycle restarts with a new one-clock strobe, the original address and direction, and beat index 0.
- R10: Backoff while idle keeps `req_ready` at 0 and starts no cycle until backoff is released.
- R11: A new request is accepted only from idle. `req_ready` is 0 while a cycle is active or held.
- R12: For write cycles, `bus_data_oe` is 1 whenever `bus_oe` is 1, and `bus_wdata` holds the request's write data. For read cycles, `bus_data_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Sequencer idle and bus not backed off |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst of BURST_LEN beats, 0 = single |
| req_wdata | input | DATA_W | Write data for the cycle |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_wr | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | DATA_W | Bus write data |
| bus_oe | output | 1 | Enable for strobe, address and direction drivers |
| bus_data_oe | output | 1 | Enable for the write data drivers |
| bus_rdy_a_n | input | 1 | Transfer ready, active low |
| bus_rdy_b_n | input | 1 | Second transfer ready, active low |
| bus_boff_n | input | 1 | Backoff, active low |
| bus_rdata | input | DATA_W | Bus read data |
| rd_valid | output | 1 | Read beat captured |
| rd_data | output | DATA_W | Captured read data |
| rd_beat | output | BEAT_W | Index of the captured beat |
| done_valid | output | 1 | Cycle complete pulse |
| done_beats | output | CNT_W | Beats in the completed cycle |

## Verification
The assertions assume that backoff and ready are synchronous levels that are stable around each rising edge. They also assume that the core holds its request fields steady while `req_valid` is high. The stimulus changes every input only on the falling edge. It holds the request until it sees `req_ready` high, and it drives ready and backoff from bounded random choices: backoff at most three times per cycle, with hold lengths of one to three clocks. Same-clock ready and backoff, ready during the strobe clock, and backoff while idle are forced in directed cases. This keeps the assertions from depending only on chance.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } bseq_state_e;
endpackage

// File: rtl/bseq_sample.sv
module bseq_sample #(
  parameter int NRDY = 2
) (
  input  logic [NRDY-1:0] rdy_n,
  input  logic            boff_n,
  output logic            any_rdy,
  output logic            boff
);
  logic [NRDY-1:0] hit;
  for (genvar g = 0; g < NRDY; g++) begin : g_rdy
    assign hit[g] = ~rdy_n[g];
  end
  assign any_rdy = |hit;
  assign boff    = ~boff_n;
endmodule

// File: rtl/bseq_beat.sv
module bseq_beat #(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic              burst,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  localparam logic [BEAT_W-1:0] LAST_BURST = BEAT_W'(BURST_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) beat <= '0;
    else if (inc)   beat <= beat + 1'b1;
  end

  assign last = burst ? (beat == LAST_BURST) : (beat == '0);
endmodule

// File: rtl/bseq_ctl.sv
module bseq_ctl
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int CNT_W  = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              any_rdy,
  input  logic              boff,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [BEAT_W-1:0] beat,
  input  logic              last,
  output logic              beat_clr,
  output logic              beat_inc,
  output logic              burst_q,
  output logic              req_ready,
  output logic              bus_ads_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_oe,
  output logic              bus_data_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_beats
);
  bseq_state_e state;
  logic        pend;
  logic        accept, restart, ack;

  assign req_ready = (state == ST_IDLE) && !boff;
  assign accept    = req_ready && req_valid;
  assign restart   = (state == ST_HOLD) && !boff && pend;
  assign ack       = (state == ST_DATA) && any_rdy && !boff;
  assign beat_clr  = accept || restart || boff;
  assign beat_inc  = ack && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend        <= 1'b0;
      bus_ads_n   <= 1'b1;
      bus_addr    <= '0;
      bus_wr      <= 1'b0;
      burst_q     <= 1'b0;
      bus_wdata   <= '0;
      bus_oe      <= 1'b0;
      bus_data_oe <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_beat     <= '0;
      done_valid  <= 1'b0;
      done_beats  <= '0;
    end else begin
      bus_ads_n  <= 1'b1;
      rd_valid   <= 1'b0;
      done_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (boff) begin
            state <= ST_HOLD;
          end else if (req_valid) begin
            state       <= ST_ADDR;
            pend        <= 1'b1;
            bus_addr    <= req_addr;
            bus_wr      <= req_write;
            burst_q     <= req_burst;
            bus_wdata   <= req_wdata;
            bus_ads_n   <= 1'b0;
            bus_oe      <= 1'b1;
            bus_data_oe <= req_write;
          end
        end
        ST_ADDR: begin
          if (boff) begin
            state       <= ST_HOLD;
            bus_oe      <= 1'b0;
            bus_data_oe <= 1'b0;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (boff) begin
            state       <= ST_HOLD;
            bus_oe      <= 1'b0;
            bus_data_oe <= 1'b0;
          end else if (any_rdy) begin
            rd_valid <= !bus_wr;
            rd_data  <= bus_rdata;
            rd_beat  <= beat;
            if (last) begin
              state       <= ST_IDLE;
              pend        <= 1'b0;
              done_valid  <= 1'b1;
              done_beats  <= CNT_W'(beat) + 1'b1;
              bus_oe      <= 1'b0;
              bus_data_oe <= 1'b0;
            end
          end
        end
        default: begin
          if (!boff) begin
            if (pend) begin
              state       <= ST_ADDR;
              bus_ads_n   <= 1'b0;
              bus_oe      <= 1'b1;
              bus_data_oe <= bus_wr;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bseq_top.sv
module bseq_top #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int CNT_W  = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_ads_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_oe,
  output logic              bus_data_oe,
  input  logic              bus_rdy_a_n,
  input  logic              bus_rdy_b_n,
  input  logic              bus_boff_n,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_beats
);
  logic              any_rdy, boff;
  logic              beat_clr, beat_inc, burst_q, last;
  logic [BEAT_W-1:0] beat;

  bseq_sample #(.NRDY(2)) i_sample (
    .rdy_n   ({bus_rdy_b_n, bus_rdy_a_n}),
    .boff_n  (bus_boff_n),
    .any_rdy (any_rdy),
    .boff    (boff)
  );

  bseq_beat #(.BURST_LEN(BURST_LEN)) i_beat (
    .clk   (clk),
    .rst   (rst),
    .clr   (beat_clr),
    .inc   (beat_inc),
    .burst (burst_q),
    .beat  (beat),
    .last  (last)
  );

  bseq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) i_ctl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_burst   (req_burst),
    .req_wdata   (req_wdata),
    .any_rdy     (any_rdy),
    .boff        (boff),
    .bus_rdata   (bus_rdata),
    .beat        (beat),
    .last        (last),
    .beat_clr    (beat_clr),
    .beat_inc    (beat_inc),
    .burst_q     (burst_q),
    .req_ready   (req_ready),
    .bus_ads_n   (bus_ads_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_oe      (bus_oe),
    .bus_data_oe (bus_data_oe),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_beat     (rd_beat),
    .done_valid  (done_valid),
    .done_beats  (done_beats)
  );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              bus_ads_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_oe,
  input logic              bus_data_oe,
  input logic              bus_boff_n,
  input logic              rd_valid,
  input logic              done_valid,
  input logic [CNT_W-1:0]  done_beats
);
  AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    !bus_ads_n |=> bus_ads_n); // R2
  AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !bus_ads_n |-> bus_oe); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_addr)); // R2
  AST_NO_BEAT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    !bus_ads_n |=> !rd_valid); // R3
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_beats == CNT_W'(1) || done_beats == CNT_W'(BURST_LEN))); // R6
  AST_BOFF_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !bus_boff_n |=> (!bus_oe && !bus_data_oe)); // R7
  AST_BOFF_BEATS_RDY: assert property (@(posedge clk) disable iff (rst)
    !bus_boff_n |=> (!rd_valid && !done_valid)); // R8
  AST_DRIVE_STARTS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> !bus_ads_n); // R9
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_oe); // R11
  AST_DATA_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> (bus_oe && bus_wr)); // R12
endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .bus_ads_n   (bus_ads_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_oe      (bus_oe),
  .bus_data_oe (bus_data_oe),
  .bus_boff_n  (bus_boff_n),
  .rd_valid    (rd_valid),
  .done_valid  (done_valid),
  .done_beats  (done_beats)
);

// File: tb/test_bseq_top.sv
`timescale 1ns/1ps
module test_bseq_top;
  localparam int AW = 32, DW = 64, BL = 4;
  localparam int BW = $clog2(BL), CW = $clog2(BL + 1);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_burst = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic bus_rdy_a_n = 1, bus_rdy_b_n = 1, bus_boff_n = 1;
  logic req_ready, bus_ads_n, bus_wr, bus_oe, bus_data_oe, rd_valid, done_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rd_data;
  logic [BW-1:0] rd_beat;
  logic [CW-1:0] done_beats;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bseq_top #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL)) i_bseq_top (.*);

  function automatic int exp_beats(input logic burst);
    return burst ? BL : 1;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one cycle; collide_beat >= 0 forces ready and backoff together at that beat once.
  task automatic run_cycle(input logic [AW-1:0] a, input logic w, input logic b,
                           input logic [DW-1:0] wd, input int collide_beat, input int max_boff);
    int phase = 0, beat = 0, hold_left = 0, restarts = 0, last;
    bit fin = 0, collided = 0;
    logic boff_d, ra, rb;
    logic [DW-1:0] rd;
    last = exp_beats(b) - 1;
    req_addr = a; req_write = w; req_burst = b; req_wdata = wd; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    chk(bus_ads_n == 0 && bus_oe == 1, "R2", "strobe/oe after accept", {bus_ads_n, bus_oe}, 2'b01);
    chk(bus_addr == a && bus_wr == w, "R2", "address/dir", bus_addr, a);
    chk(bus_data_oe == w, "R12", "data oe on start", bus_data_oe, w);
    while (!fin) begin
      ra = $urandom_range(0, 1); rb = $urandom_range(0, 1);
      if (phase == 0) ra = 0;
      if (phase == 2) begin
        boff_d = (hold_left > 0) ? 1'b0 : 1'b1;
        if (hold_left > 0) hold_left--;
      end else begin
        boff_d = (restarts < max_boff && $urandom_range(0, 7) == 0) ? 1'b0 : 1'b1;
        if (phase == 1 && beat == collide_beat && !collided) begin
          boff_d = 0; ra = 0; collided = 1;
        end
        if (!boff_d) begin hold_left = $urandom_range(0, 2); restarts++; end
      end
      rd = {$urandom, $urandom};
      bus_boff_n = boff_d; bus_rdy_a_n = ra; bus_rdy_b_n = rb; bus_rdata = rd;
      @(negedge clk);
      if (phase != 2 && !boff_d) begin
        chk(!bus_oe && !bus_data_oe, "R7", "float on backoff", {bus_oe, bus_data_oe}, 0);
        chk(!rd_valid && !done_valid, "R8", "backoff beats ready", {rd_valid, done_valid}, 0);
        phase = 2; beat = 0;
      end else if (phase == 2) begin
        if (!boff_d) chk(!bus_oe && !req_ready, "R7", "held floated", {bus_oe, req_ready}, 0);
        else begin
          chk(!bus_ads_n && bus_oe && bus_addr == a && bus_wr == w, "R9", "restart strobe/addr",
              bus_addr, a);
          phase = 0;
        end
      end else if (phase == 0) begin
        chk(bus_ads_n && !rd_valid, "R3", "ready ignored in strobe clock", {bus_ads_n, rd_valid}, 2'b10);
        chk(!req_ready, "R11", "busy not ready", req_ready, 0);
        phase = 1;
      end else if (!ra || !rb) begin
        if (!w) chk(rd_valid && rd_data == rd && rd_beat == BW'(beat),
                    (ra && !rb) ? "R4" : "R5", "read beat", rd_data, rd);
        else    chk(!rd_valid, "R12", "no read pulse on write", rd_valid, 0);
        if (beat == last) begin
          chk(done_valid && done_beats == CW'(exp_beats(b)) && !bus_oe, "R6", "completion",
              done_beats, exp_beats(b));
          fin = 1;
        end else begin
          chk(!done_valid, "R6", "no early done", done_valid, 0);
          beat++;
        end
      end else begin
        chk(!rd_valid && bus_oe, "R5", "wait state", {rd_valid, bus_oe}, 2'b01);
        if (w) chk(bus_data_oe && bus_wdata == wd, "R12", "write data driven", bus_wdata, wd);
      end
    end
    bus_boff_n = 1; bus_rdy_a_n = 1; bus_rdy_b_n = 1;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(bus_ads_n && !bus_oe && !bus_data_oe && !rd_valid && !done_valid, "R1", "in reset",
        {bus_ads_n, bus_oe, bus_data_oe, rd_valid, done_valid}, 5'b10000);
    rst = 0;
    @(negedge clk);
    chk(req_ready && bus_ads_n && !bus_oe, "R1", "after reset", {req_ready, bus_ads_n, bus_oe}, 3'b110);
    // R3: ready while idle is ignored
    bus_rdy_a_n = 0; bus_rdy_b_n = 0;
    repeat (2) @(negedge clk);
    chk(!rd_valid && !done_valid && !bus_oe, "R3", "ready while idle", {rd_valid, done_valid}, 0);
    bus_rdy_a_n = 1; bus_rdy_b_n = 1;
    // R10: backoff while idle blocks a pending request
    bus_boff_n = 0; req_valid = 1; req_addr = 32'h1000; req_write = 0; req_burst = 0;
    #1 chk(!req_ready, "R10", "not ready in idle backoff", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(bus_ads_n && !bus_oe && !req_ready, "R10", "no start during hold", {bus_ads_n, bus_oe}, 2'b10);
    bus_boff_n = 1; req_valid = 0;
    @(negedge clk);
    // directed: single read, burst read, burst write, collisions
    run_cycle(32'h1000, 0, 0, '0, -1, 0);
    run_cycle(32'h2040, 0, 1, '0, -1, 0);
    run_cycle(32'h3080, 1, 1, 64'hA5A5_0000_1111_2222, -1, 0);
    run_cycle(32'h40C0, 0, 1, '0, 2, 0);
    run_cycle(32'h5000, 0, 0, '0, 0, 0);
    // R4: second ready input alone completes a single read
    begin
      logic [DW-1:0] v;
      req_addr = 32'h6000; req_write = 0; req_burst = 0; req_valid = 1;
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      v = 64'hDEAD_BEEF_0123_4567;
      bus_rdy_a_n = 1; bus_rdy_b_n = 0; bus_rdata = v;
      @(negedge clk);
      chk(rd_valid && rd_data == v && done_valid, "R4", "ready b alone", rd_data, v);
      bus_rdy_b_n = 1;
    end
    for (int i = 0; i < 40; i++)
      run_cycle({$urandom} & 32'hFFFF_FFF8, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                {$urandom, $urandom}, -1, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule